// File: doc/BRIEF.md
# Vector-Length Configuration Unit

This unit decodes and executes one kind of instruction: a vector-length configuration word that arrives under the vector major opcode. A word encodes three things. The first is an 11-bit immediate that gives the maximum vector length. The second is a source scalar register that holds the requested length. The third is a destination scalar register. The unit reads the source through an external register-file read port. It computes the granted length and returns it through a write port.

The granted length is the smaller of the request and the immediate maximum. When the source index is zero, the immediate itself is granted. The unit keeps the maximum it last accepted and the index of the scalar register that now serves as the vector-length register. A reserved encoding, or a maximum larger than XLEN, raises an illegal-instruction trap and leaves all state alone. Words with another opcode or function field pass by untouched, so the unit can sit beside other decoders on the same instruction bus.

The unit is pipelined. Each accepted word presents its source index on the read port for one cycle. In the following cycle it reports a result with a one-cycle done pulse. A new word can be accepted every cycle. A result that is still on its way to the register file is forwarded to the word behind it.

Top module: `vlcfg_unit`

## Requirements
- R1: A word is taken only when bits 6..0 equal 1010111 and bits 14..12 equal 111. Any other valid word produces no done, no trap and no write, and the recorded maximum and register index keep their values.
- R2: A matching word with bit 31 set is reserved. It produces done and trap together, no write, and no change to the recorded maximum or register index.
- R3: Bits 30..20 hold the unsigned maximum immediate, bits 19..15 the source index and bits 11..7 the destination index.
- R4: A matching word whose immediate is greater than XLEN (64 by default) traps, with the same absence of side effects as R2. An immediate equal to XLEN is legal.
- R5: With source index 0, the granted length equals the immediate, including an immediate of 0.
- R6: With a nonzero source index, the granted length is the unsigned minimum of the source register value and the immediate.
- R7: The granted length is written to the destination register with write enable high only when the destination index is nonzero. Destination 0 gives done without a write.
- R8: A successful word records its immediate as the maximum output and its destination index as the vector-length register output. Reset clears both to 0, and a write always targets the recorded register.
- R9: The source index of a word accepted at edge N is on the read port between edges N and N+1. The done pulse, the trap and the write appear for exactly one cycle after edge N+1.
- R10: When a word reads the register that the word directly ahead of it is writing, the unit uses the value being written, not the stale register-file value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| rf_raddr_o | output | 5 | Register-file read index |
| rf_rdata_i | input | XLEN | Register-file read data (index 0 reads 0) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | XLEN | Register-file write data (granted length) |
| maxvl_o | output | 11 | Recorded maximum vector length |
| vlreg_o | output | 5 | Index of the register designated as vector length |
| trap_o | output | 1 | Illegal-instruction trap pulse |
| done_o | output | 1 | Completion pulse for every accepted word |

## Verification
The bench targets several boundaries. An immediate of exactly 64 against 65 separates an off-by-one limit check from a correct one. A source value with bit 63 set catches a signed comparison, which would grant a huge length. Destination 0 and source 0 catch a design that writes x0 or reads a real register in place of the immediate. Back-to-back words that share a register expose missing forwarding, which would grant a length computed from the stale value. A wrong funct3 or bit 31 set would show up as a spurious done, a write, or state that moves when it should hold.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
  parameter int INSTR_W = 32;
  parameter int IDX_W   = 5;
  parameter int IMM_W   = 11;
  parameter int OPC_W   = 7;
  parameter int F3_W    = 3;

  parameter logic [OPC_W-1:0] OPC_VEC = 7'b1010111;
  parameter logic [F3_W-1:0]  F3_CFG  = 3'b111;

  localparam int RD_LSB  = OPC_W;
  localparam int F3_LSB  = RD_LSB + IDX_W;
  localparam int RS1_LSB = F3_LSB + F3_W;
  localparam int IMM_LSB = RS1_LSB + IDX_W;
  localparam int RSV_BIT = IMM_LSB + IMM_W;

  typedef struct packed {
    logic             illegal;
    logic [IMM_W-1:0] imm;
    logic [IDX_W-1:0] rs1;
    logic [IDX_W-1:0] rd;
  } vlcfg_op_t;
endpackage

// File: rtl/vlcfg_decode.sv
module vlcfg_decode
  import vlcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic               hit_o,
  output vlcfg_op_t          op_o
);
  localparam logic [31:0] LIMIT = 32'(XLEN);

  logic             opc_ok;
  logic             f3_ok;
  logic             reserved;
  logic             oversize;
  logic [IMM_W-1:0] imm;

  always_comb begin
    imm      = instr_i[IMM_LSB +: IMM_W];
    opc_ok   = (instr_i[OPC_W-1:0] == OPC_VEC);
    f3_ok    = (instr_i[F3_LSB +: F3_W] == F3_CFG);
    reserved = instr_i[RSV_BIT];
    oversize = (32'(imm) > LIMIT);
    hit_o    = opc_ok && f3_ok;
    op_o.illegal = reserved || oversize;
    op_o.imm     = imm;
    op_o.rs1     = instr_i[RS1_LSB +: IDX_W];
    op_o.rd      = instr_i[RD_LSB +: IDX_W];
  end
endmodule

// File: rtl/vlcfg_calc.sv
module vlcfg_calc
  import vlcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [IDX_W-1:0] rs1_i,
  input  logic [IDX_W-1:0] rd_i,
  input  logic [XLEN-1:0]  rf_rdata_i,
  input  logic             fwd_en_i,
  input  logic [IDX_W-1:0] fwd_addr_i,
  input  logic [XLEN-1:0]  fwd_data_i,
  output logic [XLEN-1:0]  vl_o,
  output logic             wen_o
);
  logic [XLEN-1:0] imm_x;
  logic [XLEN-1:0] src;
  logic            fwd_hit;

  always_comb begin
    imm_x   = XLEN'(imm_i);
    fwd_hit = fwd_en_i && (fwd_addr_i == rs1_i);
    src     = fwd_hit ? fwd_data_i : rf_rdata_i;
    if (rs1_i == '0) begin
      vl_o = imm_x;
    end else if (src < imm_x) begin
      vl_o = src;
    end else begin
      vl_o = imm_x;
    end
    wen_o = (rd_i != '0);
  end
endmodule

// File: rtl/vlcfg_unit.sv
module vlcfg_unit
  import vlcfg_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic [IDX_W-1:0]   rf_raddr_o,
  input  logic [XLEN-1:0]    rf_rdata_i,
  output logic               rf_we_o,
  output logic [IDX_W-1:0]   rf_waddr_o,
  output logic [XLEN-1:0]    rf_wdata_o,
  output logic [IMM_W-1:0]   maxvl_o,
  output logic [IDX_W-1:0]   vlreg_o,
  output logic               trap_o,
  output logic               done_o
);
  logic            dec_hit;
  vlcfg_op_t       dec_op;

  logic            s1_vld_d, s1_vld_q;
  vlcfg_op_t       s1_q;
  logic            s1_en;

  logic [XLEN-1:0] calc_vl;
  logic            calc_wen;
  logic            exec_ok;

  logic             done_d, done_q;
  logic             trap_d, trap_q;
  logic             we_d, we_q;
  logic [IDX_W-1:0] waddr_q;
  logic [XLEN-1:0]  wdata_q;
  logic [IMM_W-1:0] maxvl_d, maxvl_q;
  logic [IDX_W-1:0] vlreg_d, vlreg_q;

  vlcfg_decode #(.XLEN(XLEN)) u_dec (
    .instr_i (instr_i),
    .hit_o   (dec_hit),
    .op_o    (dec_op)
  );

  // stage 1: accept
  always_comb begin
    s1_vld_d = instr_valid_i && dec_hit;
    s1_en    = s1_vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s1_q     <= '0;
    end else begin
      s1_vld_q <= s1_vld_d;
      if (s1_en) begin
        s1_q <= dec_op;
      end
    end
  end

  assign rf_raddr_o = s1_q.rs1;

  vlcfg_calc #(.XLEN(XLEN)) u_calc (
    .imm_i      (s1_q.imm),
    .rs1_i      (s1_q.rs1),
    .rd_i       (s1_q.rd),
    .rf_rdata_i (rf_rdata_i),
    .fwd_en_i   (we_q),
    .fwd_addr_i (waddr_q),
    .fwd_data_i (wdata_q),
    .vl_o       (calc_vl),
    .wen_o      (calc_wen)
  );

  // stage 2: execute / retire
  always_comb begin
    exec_ok = s1_vld_q && !s1_q.illegal;
    done_d  = s1_vld_q;
    trap_d  = s1_vld_q && s1_q.illegal;
    we_d    = exec_ok && calc_wen;
    maxvl_d = exec_ok ? s1_q.imm : maxvl_q;
    vlreg_d = exec_ok ? s1_q.rd  : vlreg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      maxvl_q <= '0;
      vlreg_q <= '0;
    end else begin
      done_q  <= done_d;
      trap_q  <= trap_d;
      we_q    <= we_d;
      maxvl_q <= maxvl_d;
      vlreg_q <= vlreg_d;
      if (exec_ok) begin
        waddr_q <= s1_q.rd;
        wdata_q <= calc_vl;
      end
    end
  end

  assign rf_we_o    = we_q;
  assign rf_waddr_o = waddr_q;
  assign rf_wdata_o = wdata_q;
  assign maxvl_o    = maxvl_q;
  assign vlreg_o    = vlreg_q;
  assign trap_o     = trap_q;
  assign done_o     = done_q;

  // R1
  ignored_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (!rf_we_o && !trap_o && $stable(maxvl_o) && $stable(vlreg_o)));

  // R2
  trap_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (done_o && !rf_we_o && $stable(maxvl_o) && $stable(vlreg_o)));

  // R6
  vl_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_wdata_o <= XLEN'(maxvl_o)));

  // R7
  no_x0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_waddr_o != '0 && done_o));

  // R8
  write_to_vlreg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_waddr_o == vlreg_o));

  // R9
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(instr_valid_i && dec_hit, 2));
endmodule

// File: tb/vlcfg_unit_tb.sv
`timescale 1ns/1ps
module vlcfg_unit_tb;
  localparam int XLEN = 64;

  logic            clk;
  logic            rst_n;
  logic            instr_valid_i;
  logic [31:0]     instr_i;
  logic [4:0]      rf_raddr_o;
  logic [XLEN-1:0] rf_rdata_i;
  logic            rf_we_o;
  logic [4:0]      rf_waddr_o;
  logic [XLEN-1:0] rf_wdata_o;
  logic [10:0]     maxvl_o;
  logic [4:0]      vlreg_o;
  logic            trap_o;
  logic            done_o;

  logic            tb_we;
  logic [4:0]      tb_waddr;
  logic [XLEN-1:0] tb_wdata;
  logic [XLEN-1:0] rf [32];
  logic [XLEN-1:0] sh [32];

  int n_tests;
  int n_fail;
  logic [10:0] e_maxvl;
  logic [4:0]  e_vlreg;

  vlcfg_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .maxvl_o(maxvl_o),
    .vlreg_o(vlreg_o), .trap_o(trap_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (tb_we) rf[tb_waddr] <= tb_wdata;
    else if (rf_we_o && rf_waddr_o != 5'd0) rf[rf_waddr_o] <= rf_wdata_o;
  end
  assign rf_rdata_i = (rf_raddr_o == 5'd0) ? '0 : rf[rf_raddr_o];

  task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] act,
                     input logic [XLEN-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit rsv, input logic [10:0] imm,
      input logic [4:0] rs1, input logic [2:0] f3, input logic [4:0] rd,
      input logic [6:0] opc);
    return {rsv, imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [XLEN-1:0] exp_vl(input logic [10:0] imm,
      input logic [4:0] rs1, input logic [XLEN-1:0] v);
    logic [XLEN-1:0] ix;
    ix = XLEN'(imm);
    if (rs1 == 5'd0) return ix;
    return (v < ix) ? v : ix;
  endfunction

  task automatic poke(input logic [4:0] idx, input logic [XLEN-1:0] val);
    @(negedge clk);
    tb_we = 1'b1; tb_waddr = idx; tb_wdata = val;
    @(negedge clk);
    tb_we = 1'b0;
    if (idx != 5'd0) sh[idx] = val;
  endtask

  // check one retired word against the bench model; call after edge N+1
  task automatic expect_result(input logic [31:0] w);
    bit hit, bad;
    logic [10:0] imm;
    logic [4:0]  rs1, rd;
    logic [XLEN-1:0] v;
    imm = w[30:20]; rs1 = w[19:15]; rd = w[11:7];
    hit = (w[6:0] == 7'b1010111) && (w[14:12] == 3'b111);
    bad = w[31] || (imm > 11'd64);
    if (!hit) begin
      chk(!done_o && !trap_o && !rf_we_o, "R1 ignored word quiet", {done_o, trap_o, rf_we_o}, 0);
      chk(maxvl_o == e_maxvl && vlreg_o == e_vlreg, "R1 state held", {maxvl_o, vlreg_o}, {e_maxvl, e_vlreg});
    end else if (bad) begin
      chk(done_o && trap_o && !rf_we_o, w[31] ? "R2 reserved trap" : "R4 oversize trap",
          {done_o, trap_o, rf_we_o}, 3'b110);
      chk(maxvl_o == e_maxvl && vlreg_o == e_vlreg, "R4 state held on trap",
          {maxvl_o, vlreg_o}, {e_maxvl, e_vlreg});
    end else begin
      v = exp_vl(imm, rs1, (rs1 == 5'd0) ? '0 : sh[rs1]);
      chk(done_o && !trap_o, "R9 done pulse", {done_o, trap_o}, 2'b10);
      chk(rf_we_o == (rd != 5'd0), "R7 write enable", rf_we_o, rd != 5'd0);
      if (rd != 5'd0) begin
        chk(rf_waddr_o == rd, "R3 destination field", rf_waddr_o, rd);
        chk(rf_wdata_o == v, (rs1 == 5'd0) ? "R5 immediate grant" : "R6 unsigned min",
            rf_wdata_o, v);
        sh[rd] = v;
      end
      e_maxvl = imm; e_vlreg = rd;
      chk(maxvl_o == e_maxvl && vlreg_o == e_vlreg, "R8 recorded state",
          {maxvl_o, vlreg_o}, {e_maxvl, e_vlreg});
    end
  endtask

  task automatic run(input logic [31:0] w);
    @(negedge clk);
    instr_valid_i = 1'b1; instr_i = w;
    @(negedge clk);
    instr_valid_i = 1'b0; instr_i = $urandom;
    chk(rf_raddr_o == w[19:15] || !((w[6:0] == 7'b1010111) && (w[14:12] == 3'b111)),
        "R9 read index", rf_raddr_o, w[19:15]);
    chk(!done_o, "R9 no early done", done_o, 0);
    @(negedge clk);
    expect_result(w);
    @(negedge clk);
    chk(!done_o && !trap_o && !rf_we_o, "R9 single pulse", {done_o, trap_o, rf_we_o}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w1, w2;
    n_tests = 0; n_fail = 0;
    e_maxvl = '0; e_vlreg = '0;
    instr_valid_i = 1'b0; instr_i = '0;
    tb_we = 1'b0; tb_waddr = '0; tb_wdata = '0;
    for (int i = 0; i < 32; i++) begin rf[i] = '0; sh[i] = '0; end
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(maxvl_o == 0 && vlreg_o == 0, "R8 reset state", {maxvl_o, vlreg_o}, 0);
    chk(!done_o && !trap_o && !rf_we_o, "R9 reset outputs", {done_o, trap_o, rf_we_o}, 0);

    // directed corners
    poke(5'd3, 64'd10);
    poke(5'd4, 64'h8000_0000_0000_0005);
    run(mk(0, 11'd64, 5'd0, 3'b111, 5'd5, 7'b1010111));   // R4 limit legal, R5
    run(mk(0, 11'd65, 5'd0, 3'b111, 5'd6, 7'b1010111));   // R4 over limit
    run(mk(0, 11'd0,  5'd0, 3'b111, 5'd7, 7'b1010111));   // R5 zero
    run(mk(0, 11'd20, 5'd3, 3'b111, 5'd8, 7'b1010111));   // R6 src smaller
    run(mk(0, 11'd10, 5'd3, 3'b111, 5'd9, 7'b1010111));   // R6 equal
    run(mk(0, 11'd7,  5'd4, 3'b111, 5'd10, 7'b1010111));  // R6 unsigned top bit
    run(mk(0, 11'd12, 5'd3, 3'b111, 5'd0, 7'b1010111));   // R7 x0 destination
    run(mk(1, 11'd8,  5'd3, 3'b111, 5'd11, 7'b1010111));  // R2 reserved
    run(mk(0, 11'd8,  5'd3, 3'b110, 5'd11, 7'b1010111));  // R1 wrong funct3
    run(mk(0, 11'd8,  5'd3, 3'b111, 5'd11, 7'b1010011));  // R1 wrong opcode

    // R10 back-to-back with dependency
    poke(5'd12, 64'd50);
    w1 = mk(0, 11'd30, 5'd12, 3'b111, 5'd13, 7'b1010111);
    w2 = mk(0, 11'd40, 5'd13, 3'b111, 5'd14, 7'b1010111);
    @(negedge clk); instr_valid_i = 1'b1; instr_i = w1;
    @(negedge clk); instr_i = w2;
    @(negedge clk); instr_valid_i = 1'b0;
    expect_result(w1);
    @(negedge clk);
    chk(rf_wdata_o == 64'd30 && rf_we_o, "R10 forwarded source", rf_wdata_o, 64'd30);
    expect_result(w2);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [10:0] imm;
      logic [2:0]  f3;
      logic [6:0]  opc;
      bit rsv;
      if ($urandom % 4 == 0) poke(5'($urandom % 32), ($urandom % 2) ? 64'($urandom % 90) : {$urandom, $urandom});
      imm = ($urandom % 5 == 0) ? 11'($urandom) : 11'($urandom % 70);
      f3  = ($urandom % 8 == 0) ? 3'($urandom) : 3'b111;
      opc = ($urandom % 8 == 0) ? 7'($urandom) : 7'b1010111;
      rsv = ($urandom % 10 == 0);
      run(mk(rsv, imm, 5'($urandom), f3, 5'($urandom), opc));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule